// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt lines, if any, should be presented to the processor. It is given the pending-request vector, the mask vector and the in-service vector, plus a three-bit rotation offset that says which line currently holds top priority. It finds the best unmasked request and compares it against the best line already being serviced. It raises its valid flag only when the new request strictly outranks all work in progress.

Priority is circular. The line equal to the offset ranks highest, and rank falls as the line number climbs, wrapping modulo eight. When a controller acts as the master of a cascade and runs in special fully nested mode, the cascade line's in-service bit is left out of the comparison. This lets a second request arriving through the cascade nest on top of one already being handled. The resolution is combinational. Its result is captured in an output register, so each answer is valid one clock after the inputs that produced it.

Top module: `rp_resolver`

## Requirements
- R1: The candidate set is request AND NOT mask; a line whose mask bit is 1 is never reported, whatever its request bit.
- R2: Candidates are ranked by rotated position p = (line - offset) mod 8, and smaller p wins; the line equal to the offset has top rank.
- R3: With no candidate, the valid output is 0 and the line output is 0.
- R4: The current priority is the smallest rotated position among set in-service bits, using the same offset; with no in-service bit set, any candidate is reported.
- R5: An interrupt is reported only when the best request position is strictly smaller than the current priority; a request at the same rank as, or below, the in-service work gives valid 0.
- R6: When special fully nested mode is 1 and the instance is the master, in-service bit 2 (the cascade line) is ignored in the current-priority search.
- R7: When special fully nested mode is 0, or the instance is a slave, in-service bit 2 counts like any other bit.
- R8: The reported line is (p + offset) mod 8, wrapping past line 7 to line 0.
- R9: Outputs reflect the inputs present at the previous rising clock edge; an active-low reset clears valid and line to 0 at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Pending request bits, one per line |
| mask_i | input | 8 | Mask bits, 1 blocks the line |
| isr_i | input | 8 | In-service bits, one per line |
| offset_i | input | 3 | Rotation offset, the line with top rank |
| sfnm_i | input | 1 | Special fully nested mode enable |
| is_master_i | input | 1 | 1 when this instance is the cascade master |
| irq_valid_o | output | 1 | An interrupt should be raised |
| irq_line_o | output | 3 | Line number to be raised, 0 when not valid |

## Verification
Every result is due exactly one rising edge after the inputs that produce it, because a single output register follows the combinational search. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, so each reading belongs to one input set. One directed check reads the outputs just after an input change, before any rising edge, to confirm they still hold the previous answer. The reset check reads the outputs while reset is held and again one edge after release.

// File: rtl/rp_pkg.sv
package rp_pkg;
    localparam int RP_DEF_LINES   = 8;
    localparam int RP_DEF_CASCADE = 2;

    function automatic int rp_lw(input int lines);
        return $clog2(lines);
    endfunction
endpackage

// File: rtl/rp_rot_search.sv
module rp_rot_search #(
    parameter int LINES = rp_pkg::RP_DEF_LINES,
    localparam int LW   = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec_i,
    input  logic [LW-1:0]    off_i,
    output logic [LW:0]      prio_o
);
    logic [LINES-1:0] rot;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            rot[i] = vec_i[LW'(i) + off_i];
        end
        prio_o = (LW+1)'(LINES);
        for (int i = LINES - 1; i >= 0; i--) begin
            if (rot[i]) begin
                prio_o = (LW+1)'(i);
            end
        end
    end

    // R2: a found position always points at a set bit of the input
    always_comb begin
        if (prio_o != (LW+1)'(LINES)) begin
            p_found_is_set_r2: assert (vec_i[prio_o[LW-1:0] + off_i]);
        end else begin
            p_none_means_empty_r3: assert (vec_i == '0);
        end
    end
endmodule

// File: rtl/rp_cascade_gate.sv
module rp_cascade_gate #(
    parameter int LINES   = rp_pkg::RP_DEF_LINES,
    parameter int CASCADE = rp_pkg::RP_DEF_CASCADE
) (
    input  logic [LINES-1:0] isr_i,
    input  logic             sfnm_i,
    input  logic             is_master_i,
    output logic [LINES-1:0] isr_o
);
    logic [LINES-1:0] drop;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_bit
            if (g == CASCADE) begin : g_casc
                assign drop[g] = sfnm_i & is_master_i;
            end else begin : g_plain
                assign drop[g] = 1'b0;
            end
        end
    endgenerate

    assign isr_o = isr_i & ~drop;

    // R6/R7: the gate only ever removes the cascade bit, and only in master nested mode
    always_comb begin
        p_gate_subset_r7: assert ((isr_o & ~isr_i) == '0);
        if (!(sfnm_i && is_master_i)) begin
            p_gate_pass_r7: assert (isr_o == isr_i);
        end
    end
endmodule

// File: rtl/rp_resolver.sv
module rp_resolver #(
    parameter int LINES   = rp_pkg::RP_DEF_LINES,
    parameter int CASCADE = rp_pkg::RP_DEF_CASCADE,
    localparam int LW     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] isr_i,
    input  logic [LW-1:0]    offset_i,
    input  logic             sfnm_i,
    input  logic             is_master_i,
    output logic             irq_valid_o,
    output logic [LW-1:0]    irq_line_o
);
    typedef struct packed {
        logic          valid;
        logic [LW-1:0] line;
    } res_t;

    res_t state_d, state_q;

    logic [LINES-1:0] cand;
    logic [LINES-1:0] isr_eff;
    logic [LW:0]      req_prio;
    logic [LW:0]      cur_prio;

    assign cand = req_i & ~mask_i;

    rp_cascade_gate #(.LINES(LINES), .CASCADE(CASCADE)) u_gate (
        .isr_i       (isr_i),
        .sfnm_i      (sfnm_i),
        .is_master_i (is_master_i),
        .isr_o       (isr_eff)
    );

    rp_rot_search #(.LINES(LINES)) u_req_search (
        .vec_i  (cand),
        .off_i  (offset_i),
        .prio_o (req_prio)
    );

    rp_rot_search #(.LINES(LINES)) u_cur_search (
        .vec_i  (isr_eff),
        .off_i  (offset_i),
        .prio_o (cur_prio)
    );

    always_comb begin
        state_d       = '0;
        state_d.valid = (req_prio < cur_prio);
        if (state_d.valid) begin
            state_d.line = req_prio[LW-1:0] + offset_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_valid_o = state_q.valid;
    assign irq_line_o  = state_q.line;

    // R1: a reported line was requested and unmasked on the previous edge
    p_line_is_candidate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> ((($past(req_i) & ~$past(mask_i)) >> irq_line_o) & LINES'(1)) != '0);

    // R3: nothing reported without some candidate
    p_no_cand_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> ($past(req_i) & ~$past(mask_i)) != '0);

    // R3: line stays zero while not valid
    p_idle_line_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> irq_line_o == '0);

    // R5: a reported line cannot already be in service unless it is the gated cascade line
    p_not_in_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && !($past(sfnm_i && is_master_i) && irq_line_o == LW'(CASCADE)))
        |-> ((($past(isr_i)) >> irq_line_o) & LINES'(1)) == '0);
endmodule

// File: tb/rp_resolver_tb.sv
module rp_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, mask = '0, isr = '0;
    logic [2:0] off = '0;
    logic       sfnm = 1'b0, master = 1'b0;
    logic       irq_valid;
    logic [2:0] irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rp_resolver u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .mask_i      (mask),
        .isr_i       (isr),
        .offset_i    (off),
        .sfnm_i      (sfnm),
        .is_master_i (master),
        .irq_valid_o (irq_valid),
        .irq_line_o  (irq_line)
    );

    // Entry: {req[32:25], mask[24:17], isr[16:9], off[8:6], sfnm[5], master[4], valid[3], line[2:0]}
    localparam logic [32:0] VEC [15] = '{
        {8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0},  // R1 R2 single line
        {8'hFF, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0, 1'b1, 3'd3},  // R2 offset line wins
        {8'hFF, 8'h08, 8'h00, 3'd3, 1'b0, 1'b0, 1'b1, 3'd4},  // R1 masked top line
        {8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R3 no request
        {8'hF0, 8'hF0, 8'h00, 3'd5, 1'b0, 1'b0, 1'b0, 3'd0},  // R1 R3 all masked
        {8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R5 equal rank
        {8'h02, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1},  // R4 beats service
        {8'h08, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0},  // R5 lower rank
        {8'h08, 8'h00, 8'h04, 3'd3, 1'b0, 1'b0, 1'b1, 3'd3},  // R2 R4 rotation flips
        {8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 1'b1, 3'd2},  // R6 cascade nests
        {8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0},  // R7 slave counts bit 2
        {8'h08, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 1'b1, 3'd3},  // R6 gated service
        {8'h80, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b1, 3'd7},  // R8 top line 7
        {8'h01, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 3'd0},  // R8 wrap to 0
        {8'h81, 8'h00, 8'h01, 3'd1, 1'b0, 1'b0, 1'b1, 3'd7}   // R5 R8 wrap ranks
    };

    function automatic logic [3:0] ref_res(input logic [7:0] rq, mk, is,
                                           input logic [2:0] of, input logic sf, ms);
        logic [7:0] cd, ie;
        int rp, cp;
        cd = rq & ~mk;
        ie = is;
        if (sf && ms) ie[2] = 1'b0;
        rp = 8;
        cp = 8;
        for (int p = 7; p >= 0; p--) begin
            if (cd[(p + int'(of)) % 8]) rp = p;
            if (ie[(p + int'(of)) % 8]) cp = p;
        end
        if (rp < cp) return {1'b1, 3'((rp + int'(of)) % 8)};
        return 4'b0000;
    endfunction

    task automatic check(input logic ev, input logic [2:0] el, input string tag);
        checks++;
        if (irq_valid !== ev || irq_line !== el) begin
            errors++;
            $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
                     tag, irq_valid, irq_line, ev, el);
        end
    endtask

    task automatic drive(input logic [7:0] rq, mk, is, input logic [2:0] of,
                         input logic sf, ms);
        req = rq; mask = mk; isr = is; off = of; sfnm = sf; master = ms;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [3:0]  exp;
        lfsr = 32'hACE1_1234;

        // R9: reset state while held
        drive(8'hFF, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(1'b0, 3'd0, "R9 reset held");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b1, 3'd0, "R9 one edge after release");

        // table walk
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            drive(VEC[k][32:25], VEC[k][24:17], VEC[k][16:9], VEC[k][8:6],
                  VEC[k][5], VEC[k][4]);
            @(negedge clk);
            check(VEC[k][3], VEC[k][2:0], $sformatf("R1-table entry %0d (see tags)", k));
        end

        // R9: output holds until the next rising edge
        @(negedge clk);
        drive(8'h20, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        check(1'b1, 3'd5, "R9 new value after edge");
        drive(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
        #1;
        check(1'b1, 3'd5, "R9 held before edge");
        @(negedge clk);
        check(1'b0, 3'd0, "R3 cleared after edge");

        // R2 R4 R8: every offset against the loop model
        for (int o = 0; o < 8; o++) begin
            for (int n = 0; n < 40; n++) begin
                logic [7:0] rq, mk, is;
                logic       sf, ms;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                rq = lfsr[7:0];
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                mk = lfsr[7:0] & lfsr[15:8];
                is = lfsr[23:16] & lfsr[31:24];
                sf = lfsr[9];
                ms = lfsr[12];
                drive(rq, mk, is, 3'(o), sf, ms);
                exp = ref_res(rq, mk, is, 3'(o), sf, ms);
                @(negedge clk);
                check(exp[3], exp[2:0], $sformatf("R2 R4 R8 random offset %0d", o));
            end
        end

        // R9: asynchronous reset clears a live result
        drive(8'h40, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        check(1'b1, 3'd6, "R9 before reset");
        rst_n = 1'b0;
        #1;
        check(1'b0, 3'd0, "R9 async clear");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule